// File: doc/BRIEF.md
# YUV Output Format Multiplexer

This block receives one luma sample and two chroma samples on every clock and arranges them onto three 8-bit output buses. A 2-bit mode input selects the arrangement. In full-rate mode all three channels pass through unchanged, which also suits RGB sources. In 4:2:2 mode bus A carries luma and bus B alternates between the two chroma components. In 4:1:1 mode bus B carries the two chroma samples as nibbles, spread over a group of four clocks.

A free-running phase counter sets the order of the chroma cycles. A flag bit on bus C marks the start of each chroma group, so downstream logic can tell which component is on bus B. A low-to-high edge on the init input restarts the counter, which lines the sequence up with an external reference. Each bus has its own enable. A disabled bus drives zero and holds its valid flag low. All outputs are registered.

Top module: `yuv_fmt_mux`

## Requirements
- R1: While rst_ni is low, all three data buses read zero and all three valid flags are low.
- R2: Outputs are registered. The inputs present before a rising clock edge set the outputs after that edge.
- R3: Mode 2'b10 (4:4:4): a_o = y_i, b_o = u_i, c_o = v_i.
- R4: Mode 2'b11 behaves exactly as mode 2'b10.
- R5: Mode 2'b01 (4:2:2): a_o = y_i. On even phases (0, 2) b_o = u_i and c_o = 8'h80 (flag in bit 7). On odd phases b_o = v_i and c_o = 0.
- R6: Mode 2'b00 (4:1:1): a_o = y_i and b_o[7:4] = 0. b_o[3:0] carries the group's U[7:4], U[3:0], V[7:4] and V[3:0] at phases 0, 1, 2 and 3 in that order. c_o = 8'h80 at phase 0 and 0 otherwise.
- R7: A clock in which init_i is high and was low in the previous clock takes phase 0. Holding init_i high does not restart the count again.
- R8: The phase is 0 in the first clock after reset and otherwise increases by one each clock, wrapping from 3 to 0.
- R9: A bus whose enable is low outputs zero with its valid flag low. A bus whose enable is high asserts its valid flag.
- R10: In mode 2'b00 the group's chroma pair is the u_i/v_i captured in the phase-0 clock. Changes on u_i/v_i during phases 1 to 3 have no effect on b_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| init_i | input | 1 | Phase realign, acts on its rising edge |
| mode_i | input | 2 | Output format select |
| y_i | input | 8 | Luma sample |
| u_i | input | 8 | First chroma sample |
| v_i | input | 8 | Second chroma sample |
| oe_a_i | input | 1 | Enable for bus A |
| oe_b_i | input | 1 | Enable for bus B |
| oe_c_i | input | 1 | Enable for bus C |
| a_o | output | 8 | Bus A data |
| b_o | output | 8 | Bus B data |
| c_o | output | 8 | Bus C data |
| a_vld_o | output | 1 | Bus A valid |
| b_vld_o | output | 1 | Bus B valid |
| c_vld_o | output | 1 | Bus C valid |

## Verification
Random samples run under each of the four mode codes. This separates the pass-through, alternating and nibble-packed layouts, and it exposes any swap of U and V or of the high and low nibbles. In 4:1:1 mode, chroma that changes on every clock shows whether the group pair is held from phase 0. Directed init pulses, including a long high level and edges in mid-group, separate edge detection from level detection. Random enable patterns show that each bus is gated on its own.

// File: rtl/yuv_fmt_pkg.sv
package yuv_fmt_pkg;
  typedef enum logic [1:0] {
    FMT_411  = 2'b00,
    FMT_422  = 2'b01,
    FMT_444  = 2'b10,
    FMT_444X = 2'b11
  } fmt_e;
endpackage

// File: rtl/yuv_phase_ctr.sv
module yuv_phase_ctr #(
  parameter int PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            init_i,
  output logic [PH_W-1:0] ph_o
);
  logic            init_q;
  logic            rise;
  logic [PH_W-1:0] ph_q;

  assign rise = init_i & ~init_q;
  assign ph_o = rise ? '0 : ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
      ph_q   <= '0;
    end else begin
      init_q <= init_i;
      ph_q   <= ph_o + 1'b1;
    end
  end

  assert_init_align_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise |=> ph_q == PH_W'(1));
  assert_phase_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rise |=> ph_q == $past(ph_q) + 1'b1);
endmodule

// File: rtl/yuv_chroma_pack.sv
module yuv_chroma_pack
  import yuv_fmt_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  fmt_e            fmt_i,
  input  logic [PH_W-1:0] ph_i,
  input  logic [DW-1:0]   y_i,
  input  logic [DW-1:0]   u_i,
  input  logic [DW-1:0]   v_i,
  output logic [DW-1:0]   a_d_o,
  output logic [DW-1:0]   b_d_o,
  output logic [DW-1:0]   c_d_o
);
  localparam int NW = DW / 2;
  localparam logic [DW-1:0] FLAG = DW'(1) << (DW - 1);

  logic [DW-1:0] hu_q, hv_q, gu, gv;

  // group pair: live at phase 0, held afterwards
  assign gu = (ph_i == '0) ? u_i : hu_q;
  assign gv = (ph_i == '0) ? v_i : hv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hu_q <= '0;
      hv_q <= '0;
    end else if (ph_i == '0) begin
      hu_q <= u_i;
      hv_q <= v_i;
    end
  end

  always_comb begin
    a_d_o = y_i;
    b_d_o = u_i;
    c_d_o = v_i;
    unique case (fmt_i)
      FMT_422: begin
        b_d_o = ph_i[0] ? v_i : u_i;
        c_d_o = ph_i[0] ? '0 : FLAG;
      end
      FMT_411: begin
        unique case (ph_i[1:0])
          2'd0: b_d_o = {{(DW-NW){1'b0}}, gu[DW-1:NW]};
          2'd1: b_d_o = {{(DW-NW){1'b0}}, gu[NW-1:0]};
          2'd2: b_d_o = {{(DW-NW){1'b0}}, gv[DW-1:NW]};
          default: b_d_o = {{(DW-NW){1'b0}}, gv[NW-1:0]};
        endcase
        c_d_o = (ph_i == '0) ? FLAG : '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/yuv_out_reg.sv
module yuv_out_reg #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          oe_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o,
  output logic          vld_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      d_o   <= oe_i ? d_i : '0;
      vld_o <= oe_i;
    end
  end

  assert_gate_off_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_i |=> (d_o == '0 && !vld_o));
  assert_gate_on_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_i |=> (vld_o && d_o == $past(d_i)));
  always_comb if (!rst_ni) assert_rst_clear_R1: assert (d_o == '0 && !vld_o);
endmodule

// File: rtl/yuv_fmt_mux.sv
module yuv_fmt_mux
  import yuv_fmt_pkg::*;
#(
  parameter int DW   = 8,
  parameter int PH_W = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          init_i,
  input  logic [1:0]    mode_i,
  input  logic [DW-1:0] y_i,
  input  logic [DW-1:0] u_i,
  input  logic [DW-1:0] v_i,
  input  logic          oe_a_i,
  input  logic          oe_b_i,
  input  logic          oe_c_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output logic [DW-1:0] c_o,
  output logic          a_vld_o,
  output logic          b_vld_o,
  output logic          c_vld_o
);
  localparam int NBUS = 3;

  logic [PH_W-1:0] ph;
  logic [DW-1:0]   d_nxt [NBUS];
  logic [DW-1:0]   d_q   [NBUS];
  logic [NBUS-1:0] oe, vld;

  assign oe = {oe_c_i, oe_b_i, oe_a_i};

  yuv_phase_ctr #(.PH_W(PH_W)) i_phase (
    .clk_i, .rst_ni, .init_i, .ph_o(ph)
  );

  yuv_chroma_pack #(.DW(DW), .PH_W(PH_W)) i_pack (
    .clk_i, .rst_ni, .fmt_i(fmt_e'(mode_i)), .ph_i(ph),
    .y_i, .u_i, .v_i,
    .a_d_o(d_nxt[0]), .b_d_o(d_nxt[1]), .c_d_o(d_nxt[2])
  );

  for (genvar i = 0; i < NBUS; i++) begin : g_bus
    yuv_out_reg #(.DW(DW)) i_out (
      .clk_i, .rst_ni, .oe_i(oe[i]), .d_i(d_nxt[i]), .d_o(d_q[i]), .vld_o(vld[i])
    );
  end

  assign a_o = d_q[0];
  assign b_o = d_q[1];
  assign c_o = d_q[2];
  assign {c_vld_o, b_vld_o, a_vld_o} = vld;

  assert_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10 && &oe) |=> (a_o == $past(y_i) && b_o == $past(u_i) && c_o == $past(v_i)));
  assert_alt_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && &oe) |=> (b_o == $past(u_i) && c_o == $past(v_i)));
  assert_u_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && oe_c_i && !ph[0]) |=> c_o[DW-1]);
  assert_group_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b00 && oe_c_i && ph != '0) |=> c_o == '0);
endmodule

// File: tb/test_yuv_fmt_mux.sv
module test_yuv_fmt_mux;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst_n = 1'b0, init = 1'b0;
  logic [1:0] mode = 2'b10;
  logic [7:0] y = '0, u = '0, v = '0;
  logic oe_a = 1'b1, oe_b = 1'b1, oe_c = 1'b1;
  logic [7:0] a_o, b_o, c_o;
  logic a_vld, b_vld, c_vld;

  int checks = 0, errors = 0;
  int ph_m = 0;
  logic init_prev = 1'b0;
  logic [7:0] hu = '0, hv = '0;
  logic [7:0] ea, eb, ec;
  logic eva, evb, evc;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  yuv_fmt_mux i_yuv_fmt_mux (
    .clk_i(clk), .rst_ni(rst_n), .init_i(init), .mode_i(mode),
    .y_i(y), .u_i(u), .v_i(v), .oe_a_i(oe_a), .oe_b_i(oe_b), .oe_c_i(oe_c),
    .a_o(a_o), .b_o(b_o), .c_o(c_o), .a_vld_o(a_vld), .b_vld_o(b_vld), .c_vld_o(c_vld)
  );

  task automatic chk(string tag, string what, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic string mode_tag(logic [1:0] m);
    case (m)
      2'b00: return "R6";
      2'b01: return "R5";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  // drive at negedge, model, check after next posedge
  task automatic step(logic [7:0] yy, logic [7:0] uu, logic [7:0] vv, logic in, logic [1:0] md,
                      logic [2:0] en, string tag);
    int ph;
    logic [7:0] da, db, dc;
    y = yy; u = uu; v = vv; init = in; mode = md; {oe_c, oe_b, oe_a} = en;
    ph = (in && !init_prev) ? 0 : ph_m;
    if (ph == 0) begin hu = uu; hv = vv; end
    da = yy; db = uu; dc = vv;
    if (md == 2'b01) begin
      db = ph[0] ? vv : uu;
      dc = ph[0] ? 8'h00 : 8'h80;
    end else if (md == 2'b00) begin
      case (ph)
        0: db = {4'h0, hu[7:4]};
        1: db = {4'h0, hu[3:0]};
        2: db = {4'h0, hv[7:4]};
        default: db = {4'h0, hv[3:0]};
      endcase
      dc = (ph == 0) ? 8'h80 : 8'h00;
    end
    ea = en[0] ? da : 8'h00; eva = en[0];
    eb = en[1] ? db : 8'h00; evb = en[1];
    ec = en[2] ? dc : 8'h00; evc = en[2];
    ph_m = (ph + 1) % 4;
    init_prev = in;
    @(posedge clk);
    @(negedge clk);
    chk(en[0] ? tag : "R9", "bus A", {a_vld, a_o}, {eva, ea});
    chk(en[1] ? tag : "R9", "bus B", {b_vld, b_o}, {evb, eb});
    chk(en[2] ? tag : "R9", "bus C", {c_vld, c_o}, {evc, ec});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "reset A", {a_vld, a_o}, 9'h000);
    chk("R1", "reset B", {b_vld, b_o}, 9'h000);
    chk("R1", "reset C", {c_vld, c_o}, 9'h000);
    rst_n = 1'b1;

    // R8 first group after reset, R2 latency, 4:1:1 directed
    step(8'h11, 8'hA5, 8'h3C, 0, 2'b00, 3'b111, "R8");
    step(8'h22, 8'hFF, 8'hFF, 0, 2'b00, 3'b111, "R10");
    step(8'h33, 8'h00, 8'h00, 0, 2'b00, 3'b111, "R10");
    step(8'h44, 8'h77, 8'h77, 0, 2'b00, 3'b111, "R10");
    step(8'h55, 8'h12, 8'h34, 0, 2'b00, 3'b111, "R6");
    // R7 init edge mid-group then held high
    step(8'h66, 8'h9A, 8'hBC, 1, 2'b00, 3'b111, "R7");
    step(8'h67, 8'h01, 8'h02, 1, 2'b00, 3'b111, "R7");
    step(8'h68, 8'h03, 8'h04, 1, 2'b00, 3'b111, "R7");
    step(8'h69, 8'h05, 8'h06, 1, 2'b00, 3'b111, "R7");
    step(8'h6A, 8'h07, 8'h08, 1, 2'b00, 3'b111, "R7");
    step(8'h6B, 8'h09, 8'h0A, 0, 2'b01, 3'b111, "R5");
    step(8'h6C, 8'h0B, 8'h0C, 1, 2'b01, 3'b111, "R7");
    step(8'h6D, 8'h0D, 8'h0E, 1, 2'b01, 3'b111, "R5");
    // R9 each bus alone off
    step(8'hE1, 8'hE2, 8'hE3, 0, 2'b10, 3'b110, "R9");
    step(8'hE4, 8'hE5, 8'hE6, 0, 2'b10, 3'b101, "R9");
    step(8'hE7, 8'hE8, 8'hE9, 0, 2'b11, 3'b011, "R9");
    step(8'hEA, 8'hEB, 8'hEC, 0, 2'b11, 3'b000, "R9");

    // random mix, R2 latency throughout
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] md;
      logic [2:0] en;
      logic in;
      md = 2'($urandom_range(0, 3));
      en = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'b111;
      in = ($urandom_range(0, 15) == 0);
      step(8'($urandom), 8'($urandom), 8'($urandom), in, md, en,
           (i % 50 == 0) ? "R2" : mode_tag(md));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule